// File: doc/BRIEF.md
# Dual-Lane Serial Frame Shifter

This block is the host end of a two-wire-in, one-wire-out programming link. One strobe sends a single frame. The frame carries a data byte and an instruction byte at the same time, on two separate output lanes. A serial clock paces the frame, and the block generates that clock from its own system clock. In the same frame, the block collects the byte that the target returns on a response line.

Each lane carries 11 bit slots:
- one leading zero,
- the byte, most significant bit first,
- two trailing zeros.

The target clocks the lanes in on the rising edge of the serial clock. The block moves the lanes only on the falling edge, so setup and hold margins of about half a period are left on both sides of every rising edge.

The response byte comes back in the first eight slots. The target updates the response line shortly after each rising edge. The block samples it at the end of the low phase that follows, just before the next rising edge. The response line is ignored in the last three slots.

Grouping frames into complete programming operations is done by a sequencer around this block.

Top module: `dual_lane_frame_shifter`

## Requirements
- R1: After reset, `ser_clk_o`, `data_lane_o`, `instr_lane_o`, `done_o` and `resp_byte_o` are all 0.
- R2: A frame has exactly 11 serial clock periods, and the serial clock idles low between frames. `done_o` is high for exactly one system cycle, in the cycle after the eleventh falling edge. That is 22·HALF_DIV+1 system cycles after the cycle in which the start was presented.
- R3: Both lanes carry 11 slots in this order: a 0, then the 8-bit input byte MSB first, then 0, 0. Slot 0 is presented before the first rising edge.
- R4: Every high phase and every low phase of the serial clock lasts HALF_DIV system cycles. For the default parameters this is at least 110 ns, including the first low phase of a frame that starts in the cycle right after `done_o`.
- R5: The lanes change only while the serial clock is low, and at least 50 ns away from any rising edge.
- R6: `resp_byte_o` holds the response line values seen in slots 0 to 7, with slot 0 in bit 7. Each value is sampled at the end of the low phase after that slot's rising edge. The line's value in slots 8 to 10 has no effect. The byte is valid when `done_o` is high.
- R7: A start while a frame is in flight is ignored. The current frame's lane contents are unchanged, and it produces only one `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Starts a frame when the block is idle |
| data_byte_i | input | 8 | Byte sent on the data lane |
| instr_byte_i | input | 8 | Byte sent on the instruction lane |
| resp_byte_o | output | 8 | Byte captured from the response line |
| done_o | output | 1 | One-cycle pulse when a frame completes |
| ser_clk_o | output | 1 | Serial clock to the target |
| data_lane_o | output | 1 | Serial data lane |
| instr_lane_o | output | 1 | Serial instruction lane |
| resp_lane_i | input | 1 | Response line from the target |

## Verification
The start strobe is presented on a falling system edge. The done pulse is due at the 22·HALF_DIV+1th falling system edge after that; the bench counts edges up to that point and compares the count. At that pulse, three results are due together: the captured byte, the lane words, and the count of rising edges. A scoreboard monitor compares all three at the first falling system edge on which `done_o` is high, and requires `done_o` to be low again one edge later.

A behavioural target measures every phase width and every setup and hold interval in real time, and the scoreboard reads its error counts at that same point.

// File: rtl/dlfs_pkg.sv
package dlfs_pkg;

    localparam int BYTE_W      = 8;
    localparam int LEAD_ZEROS  = 1;
    localparam int TRAIL_ZEROS = 2;
    localparam int FRAME_SLOTS = LEAD_ZEROS + BYTE_W + TRAIL_ZEROS;
    localparam int SLOT_W      = $clog2(FRAME_SLOTS);
    localparam int NUM_LANES   = 2;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } phase_e;

    // build the 11-slot word for one lane, first slot at the MSB
    function automatic logic [FRAME_SLOTS-1:0] frame_word(input logic [BYTE_W-1:0] b);
        return {{LEAD_ZEROS{1'b0}}, b, {TRAIL_ZEROS{1'b0}}};
    endfunction

    // response bit of slot s-1 is sampled at the end of slot s low phase
    function automatic logic is_capture_slot(input logic [SLOT_W-1:0] s);
        return (s >= SLOT_W'(1)) && (s <= SLOT_W'(BYTE_W));
    endfunction

endpackage

// File: rtl/dlfs_half_timer.sv
module dlfs_half_timer #(
    parameter int HALF_DIV = 28
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    output logic tick_o
);
    localparam int CNT_W = $clog2(HALF_DIV + 1);

    logic [CNT_W-1:0] cnt_q;

    assign tick_o = run_i && (cnt_q == CNT_W'(HALF_DIV - 1));

    always_ff @(posedge clk) begin
        if (rst || !run_i || tick_o) cnt_q <= '0;
        else                         cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/dlfs_lane_shift.sv
module dlfs_lane_shift #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic         shift_i,
    input  logic [W-1:0] load_val_i,
    output logic         bit_o
);
    logic [W-1:0] sr_q;

    always_ff @(posedge clk) begin
        if (rst)          sr_q <= '0;
        else if (load_i)  sr_q <= load_val_i;
        else if (shift_i) sr_q <= {sr_q[W-2:0], 1'b0};
    end

    assign bit_o = sr_q[W-1];

    // R3
    lead_zero_chk: assert property (@(posedge clk) disable iff (rst)
        load_i |=> !bit_o);
endmodule

// File: rtl/dlfs_resp_capture.sv
module dlfs_resp_capture #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en_i,
    input  logic         bit_i,
    output logic [W-1:0] byte_o
);
    always_ff @(posedge clk) begin
        if (rst)       byte_o <= '0;
        else if (en_i) byte_o <= {byte_o[W-2:0], bit_i};
    end
endmodule

// File: rtl/dual_lane_frame_shifter.sv
module dual_lane_frame_shifter
    import dlfs_pkg::*;
#(
    parameter int HALF_DIV    = 28,
    parameter int SYS_CLK_MHZ = 250,
    parameter int MIN_HALF_NS = 110
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    input  logic [7:0] data_byte_i,
    input  logic [7:0] instr_byte_i,
    output logic [7:0] resp_byte_o,
    output logic       done_o,
    output logic       ser_clk_o,
    output logic       data_lane_o,
    output logic       instr_lane_o,
    input  logic       resp_lane_i
);
    localparam int MIN_HALF_CYC = (MIN_HALF_NS * SYS_CLK_MHZ + 999) / 1000;
    localparam int RUN_W        = $clog2(MIN_HALF_CYC + 1);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(FRAME_SLOTS - 1);

    phase_e            phase_q;
    logic [SLOT_W-1:0] slot_q;
    logic              sci_q;
    logic              done_q;
    logic              tick;
    logic              load, shift, cap_en;

    logic [NUM_LANES-1:0][BYTE_W-1:0] lane_byte;
    logic [NUM_LANES-1:0]             lane_bit;

    dlfs_half_timer #(.HALF_DIV(HALF_DIV)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .run_i  (phase_q != PH_IDLE),
        .tick_o (tick)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            slot_q  <= '0;
            sci_q   <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (phase_q)
                PH_IDLE: if (start_i) begin
                    phase_q <= PH_LOW;
                    slot_q  <= '0;
                end
                PH_LOW: if (tick) begin
                    phase_q <= PH_HIGH;
                    sci_q   <= 1'b1;
                end
                PH_HIGH: if (tick) begin
                    sci_q <= 1'b0;
                    if (slot_q == LAST_SLOT) begin
                        phase_q <= PH_IDLE;
                        done_q  <= 1'b1;
                    end else begin
                        phase_q <= PH_LOW;
                        slot_q  <= slot_q + 1'b1;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign load   = (phase_q == PH_IDLE) && start_i;
    assign shift  = (phase_q == PH_HIGH) && tick && (slot_q != LAST_SLOT);
    assign cap_en = (phase_q == PH_LOW) && tick && is_capture_slot(slot_q);

    assign lane_byte[0] = data_byte_i;
    assign lane_byte[1] = instr_byte_i;

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        dlfs_lane_shift #(.W(FRAME_SLOTS)) u_shift (
            .clk        (clk),
            .rst        (rst),
            .load_i     (load),
            .shift_i    (shift),
            .load_val_i (frame_word(lane_byte[g])),
            .bit_o      (lane_bit[g])
        );
    end

    dlfs_resp_capture #(.W(BYTE_W)) u_cap (
        .clk    (clk),
        .rst    (rst),
        .en_i   (cap_en),
        .bit_i  (resp_lane_i),
        .byte_o (resp_byte_o)
    );

    assign ser_clk_o    = sci_q;
    assign done_o       = done_q;
    assign data_lane_o  = lane_bit[0];
    assign instr_lane_o = lane_bit[1];

    // phase-width monitors, saturating at the required minimum
    logic [RUN_W-1:0] hi_run_q, lo_run_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            hi_run_q <= '0;
            lo_run_q <= '0;
        end else begin
            hi_run_q <= !sci_q ? '0 :
                        (hi_run_q == RUN_W'(MIN_HALF_CYC)) ? hi_run_q : hi_run_q + 1'b1;
            lo_run_q <= sci_q ? '0 :
                        (lo_run_q == RUN_W'(MIN_HALF_CYC)) ? lo_run_q : lo_run_q + 1'b1;
        end
    end

    // R4
    hi_width_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(sci_q) |-> (hi_run_q >= RUN_W'(MIN_HALF_CYC)));

    // R4
    lo_width_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sci_q) |-> (lo_run_q >= RUN_W'(MIN_HALF_CYC)));

    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

    // R2
    done_idle_low_chk: assert property (@(posedge clk) disable iff (rst)
        done_q |-> (!sci_q && phase_q == PH_IDLE));

    // R5
    lane_hold_chk: assert property (@(posedge clk) disable iff (rst)
        sci_q |-> $stable(lane_bit));

    // R7
    busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q != PH_IDLE && start_i) |=> (phase_q != PH_IDLE || done_q));
endmodule

// File: tb/sim_dual_lane_frame_shifter.sv
`timescale 1ns/1ps
module sim_dual_lane_frame_shifter;
    localparam int HALF = 28;
    localparam int LATENCY = 22 * HALF + 1;

    typedef struct {
        logic [7:0] dat;
        logic [7:0] ins;
        logic [7:0] ret;
    } item_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_i = 1'b0;
    logic [7:0] data_byte_i = '0, instr_byte_i = '0;
    logic [7:0] resp_byte_o;
    logic       done_o, ser_clk_o, data_lane_o, instr_lane_o;
    logic       resp_line = 1'b1;

    int n_chk = 0, n_fail = 0, n_done = 0, n_sent = 0;
    bit finished = 0;
    item_t exp_q[$];

    always #2 clk = ~clk;

    dual_lane_frame_shifter #(.HALF_DIV(HALF)) u0 (
        .clk(clk), .rst(rst), .start_i(start_i),
        .data_byte_i(data_byte_i), .instr_byte_i(instr_byte_i),
        .resp_byte_o(resp_byte_o), .done_o(done_o),
        .ser_clk_o(ser_clk_o), .data_lane_o(data_lane_o),
        .instr_lane_o(instr_lane_o), .resp_lane_i(resp_line)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // behavioural target
    real t_rise = -1000.0, t_fall = -1000.0, t_lane = -1000.0;
    int  rises = 0, err_w = 0, err_s = 0;
    logic [10:0] rx_d = '0, rx_i = '0;
    logic [7:0]  ret_cur = '0;

    always @(data_lane_o or instr_lane_o) begin
        if ($realtime - t_rise < 50.0) err_s++;
        t_lane = $realtime;
    end

    always @(posedge ser_clk_o) begin
        if ($realtime - t_lane < 50.0) err_s++;
        if ($realtime - t_fall < 110.0) err_w++;
        t_rise = $realtime;
        if (rises == 0 && exp_q.size() > 0) ret_cur = exp_q[0].ret;
        rx_d = {rx_d[9:0], data_lane_o};
        rx_i = {rx_i[9:0], instr_lane_o};
        resp_line <= #16 ((rises < 8) ? ret_cur[7-rises] : ~ret_cur[0]);
        rises++;
    end

    always @(negedge ser_clk_o) begin
        if ($realtime - t_rise < 110.0) err_w++;
        t_fall = $realtime;
    end

    // scoreboard monitor
    logic prev_done = 1'b0;
    always @(negedge clk) begin
        if (!rst) begin
            if (prev_done && done_o) chk("R2 done one cycle", 1, 0);
            if (done_o) begin
                item_t it;
                n_done++;
                if (exp_q.size() == 0) chk("R7 unexpected done", 1, 0);
                else begin
                    it = exp_q.pop_front();
                    chk("R6 response byte", resp_byte_o, it.ret);
                    chk("R3 data lane word", rx_d, {1'b0, it.dat, 2'b00});
                    chk("R3 instr lane word", rx_i, {1'b0, it.ins, 2'b00});
                    chk("R2 rising edges", rises, 11);
                    chk("R2 clock idles low", ser_clk_o, 0);
                    chk("R4 phase widths", err_w, 0);
                    chk("R5 setup hold", err_s, 0);
                end
                rises = 0; err_w = 0; err_s = 0;
            end
            prev_done = done_o;
        end
    end

    // driver
    task automatic send(input logic [7:0] d, input logic [7:0] i,
                        input logic [7:0] r, input bit poke);
        int cyc = 0;
        item_t it;
        it.dat = d; it.ins = i; it.ret = r;
        exp_q.push_back(it);
        n_sent++;
        data_byte_i = d; instr_byte_i = i; start_i = 1'b1;
        do begin
            @(negedge clk);
            cyc++;
            start_i = 1'b0;
            data_byte_i = ~d; instr_byte_i = ~i;
            if (poke && cyc == 300) begin
                start_i = 1'b1;   // R7: must be ignored
            end
        end while (!done_o && cyc < 2 * LATENCY);
        chk("R2 done latency", cyc, LATENCY);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        chk("R1 ser_clk", ser_clk_o, 0);
        chk("R1 lanes", {data_lane_o, instr_lane_o}, 0);
        chk("R1 done", done_o, 0);
        chk("R1 resp", resp_byte_o, 0);
        repeat (20) @(negedge clk);
        send(8'hA5, 8'h4C, 8'h3C, 0);
        repeat (50) @(negedge clk);
        // back-to-back frames (R4 first low phase)
        send(8'hFF, 8'h00, 8'h81, 0);
        send(8'h00, 8'hFF, 8'h00, 0);
        send(8'h01, 8'h80, 8'hFF, 0);
        send(8'h80, 8'h01, 8'h7E, 0);
        // R7 busy start
        send(8'h5A, 8'h2C, 8'hC3, 1);
        repeat (30) @(negedge clk);
        send(8'h10, 8'h1C, 8'h96, 0);
        repeat (HALF * 4) @(negedge clk);
        chk("R7 done count", n_done, n_sent);
        chk("R2 idle after frames", ser_clk_o, 0);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule